// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a logical address into a physical one by walking a fixed tree of three descriptor tables: a root table, a pointer table and a page table. A request carries the logical address, a three-bit function code, a write flag and a probe flag. The walker reads 32-bit descriptors over a simple request/acknowledge memory port. It sets the used and modified bookkeeping bits in the descriptors it passes through. It returns the physical address, a fault flag and a status byte. Page size is chosen by a configuration pin, either 4 KB or 8 KB. Two table base inputs give the root tables for supervisor and user accesses.

The request and response sides are valid/ready streams. The request side accepts a walk only while the walker is idle, so `req_ready` is high exactly when no walk is in flight. A response stays on `rsp_valid` with stable payload until the consumer raises `rsp_ready`. The walker accepts no new request until that handshake completes. The memory port holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`, and `mem_err` with the acknowledge marks a bus error. A probe walk follows the same path but only reports: it writes nothing and never raises a fault.

Top module: `walk3_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high, and only one walk is in flight. `rsp_valid` stays high with unchanged `rsp_paddr`, `rsp_fault` and `rsp_status` until `rsp_ready` is seen.
- R3: Once raised, `mem_req` stays high with unchanged `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack`. Each walk makes exactly one memory access per descriptor read or write-back.
- R4: The root descriptor is read from the supervisor base when function-code bit 2 is 1, and from the user base otherwise. The offset is logical address bits 31:25 times 4.
- R5: The pointer descriptor is read at (root descriptor with bits 8:0 cleared) plus address bits 24:18 times 4. A root or pointer descriptor with bit 1 clear ends the walk with status bit 1 (invalid) and a fault.
- R6: A valid root or pointer descriptor with bit 3 (used) clear is written back to its own address with bit 3 set, before the next descriptor is read.
- R7: Bit 2 of a root, pointer or resident page descriptor marks write protection. Any such bit on the path sets status bit 2, and a write access through it faults.
- R8: With `cfg_big_page` = 1, the page descriptor is read at (pointer descriptor with bits 6:0 cleared) plus address bits 17:13 times 4. The physical address is then descriptor bits 31:13 joined with address bits 12:0. With `cfg_big_page` = 0, the read is at (pointer with bits 7:0 cleared) plus bits 17:12 times 4, and the physical address is descriptor bits 31:12 joined with address bits 11:0.
- R9: A page-level descriptor with type field (bits 1:0) equal to 2 is indirect. The walker next reads the word at that descriptor with bits 1:0 cleared, and repeats while the type stays 2.
- R10: A final page descriptor of type 0 faults with status bit 1. One with bit 7 set faults for a user access (function-code bit 2 = 0) and sets status bit 3.
- R11: A resident page (type 1 or 3) gains bit 3, and on a write also bit 4 (modified). It is written back only if its value changed. Status bit 0 marks a resident translation, and status bit 5 mirrors the page's modified bit.
- R12: A probe walk performs no memory write and returns `rsp_fault` = 0. It still records status bits and the physical address of a resident page.
- R13: `mem_err` with any acknowledge ends the walk with status bit 4 and a fault, unless probing. Whenever `rsp_fault` is 1, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_page | input | 1 | 1 selects 8 KB pages, 0 selects 4 KB pages |
| root_sup | input | 32 | Supervisor root table base |
| root_usr | input | 32 | User root table base |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Logical address |
| req_fc | input | 3 | Function code; bit 2 means supervisor |
| req_write | input | 1 | 1 for a write access |
| req_probe | input | 1 | 1 for a report-only walk |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Walk faulted |
| rsp_status | output | 8 | Status bits as listed in the requirements |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a descriptor write-back |
| mem_addr | output | 32 | Descriptor address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Bus error, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench builds the walker with its default status width of eight bits. Page size is a run-time pin rather than a parameter, so one build covers both geometries. A pointer descriptor with bit 7 set tells them apart, because 8 KB pages keep that bit in the page-table base and 4 KB pages clear it. That build also reaches chained indirect pages, protection at the root and page levels, supervisor-only pages, bus errors at pointer level and probe walks. Response back-pressure is applied throughout.

// File: rtl/walk3_pkg.sv
package walk3_pkg;
  localparam int WORD_W   = 32;
  // logical address index fields
  localparam int ROOT_HI  = 31;
  localparam int ROOT_LO  = 25;
  localparam int PTR_HI   = 24;
  localparam int PTR_LO   = 18;
  localparam int PG_HI    = 17;
  localparam int PG4_LO   = 12;
  localparam int PG8_LO   = 13;
  // base alignment per table kind
  localparam int PTR_CLR  = 9;
  localparam int PGT4_CLR = 8;
  localparam int PGT8_CLR = 7;
  localparam int IND_CLR  = 2;
  // descriptor bits
  localparam int D_VALID  = 1;
  localparam int D_WP     = 2;
  localparam int D_USED   = 3;
  localparam int D_MOD    = 4;
  localparam int D_SUP    = 7;
  localparam logic [1:0] T_INV = 2'd0;
  localparam logic [1:0] T_IND = 2'd2;
  // status bits
  localparam int S_RES  = 0;
  localparam int S_INV  = 1;
  localparam int S_WP   = 2;
  localparam int S_SUP  = 3;
  localparam int S_BERR = 4;
  localparam int S_MOD  = 5;
  localparam int S_USED_W = 6;

  typedef enum logic [1:0] {LV_ROOT, LV_PTR, LV_PAGE} level_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} state_e;
endpackage

// File: rtl/walk3_index.sv
module walk3_index
  import walk3_pkg::*;
(
  input  logic [WORD_W-1:0] req_va,
  input  logic              req_sup,
  input  logic [WORD_W-1:0] root_sup,
  input  logic [WORD_W-1:0] root_usr,
  input  logic [WORD_W-1:0] walk_va,
  input  logic [WORD_W-1:0] prev,
  input  logic              big_page,
  output logic [WORD_W-1:0] root_addr,
  output logic [WORD_W-1:0] ptr_addr,
  output logic [WORD_W-1:0] page_addr,
  output logic [WORD_W-1:0] ind_addr
);
  localparam int RIW = ROOT_HI - ROOT_LO + 1;
  localparam int PIW = PTR_HI - PTR_LO + 1;
  localparam int G4W = PG_HI - PG4_LO + 1;
  localparam int G8W = PG_HI - PG8_LO + 1;

  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] pg4_addr, pg8_addr;

  assign base      = req_sup ? root_sup : root_usr;
  assign root_addr = base + WORD_W'({req_va[ROOT_HI:ROOT_LO], 2'b00});
  assign ptr_addr  = {prev[WORD_W-1:PTR_CLR], {PTR_CLR{1'b0}}}
                   + WORD_W'({walk_va[PTR_HI:PTR_LO], 2'b00});
  assign pg4_addr  = {prev[WORD_W-1:PGT4_CLR], {PGT4_CLR{1'b0}}}
                   + WORD_W'({walk_va[PG_HI:PG4_LO], 2'b00});
  assign pg8_addr  = {prev[WORD_W-1:PGT8_CLR], {PGT8_CLR{1'b0}}}
                   + WORD_W'({walk_va[PG_HI:PG8_LO], 2'b00});
  assign page_addr = big_page ? pg8_addr : pg4_addr;
  assign ind_addr  = {prev[WORD_W-1:IND_CLR], {IND_CLR{1'b0}}};

  // index widths are fixed by the tree shape
  initial begin
    if (RIW != 7 || PIW != 7 || G4W != 6 || G8W != 5)
      $display("walk3_index: unexpected index geometry");
  end
endmodule

// File: rtl/walk3_judge.sv
module walk3_judge
  import walk3_pkg::*;
#(
  parameter int unsigned STAT_W = 8
)(
  input  level_e            lvl,
  input  logic [WORD_W-1:0] desc,
  input  logic [WORD_W-1:0] walk_va,
  input  logic              big_page,
  input  logic              is_write,
  input  logic              is_user,
  input  logic              is_probe,
  input  logic [WORD_W-1:0] ptr_addr,
  input  logic [WORD_W-1:0] page_addr,
  input  logic [WORD_W-1:0] ind_addr,
  output logic              finish,
  output logic              fault,
  output logic              wb,
  output logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] next_addr,
  output level_e            next_lvl,
  output logic [STAT_W-1:0] stat,
  output logic [WORD_W-1:0] paddr
);
  logic [WORD_W-1:0] upd;
  logic sup_hit, viol;

  always_comb begin
    upd = desc;
    upd[D_USED] = 1'b1;
    if (is_write) upd[D_MOD] = 1'b1;
  end

  assign sup_hit = desc[D_SUP] && is_user;
  assign viol    = (desc[D_WP] && is_write) || sup_hit;

  always_comb begin
    finish    = 1'b0;
    fault     = 1'b0;
    wb        = 1'b0;
    wdata     = desc;
    next_addr = '0;
    next_lvl  = lvl;
    stat      = '0;
    paddr     = '0;
    case (lvl)
      LV_ROOT, LV_PTR: begin
        if (!desc[D_VALID]) begin
          stat[S_INV] = 1'b1;
          finish      = 1'b1;
          fault       = !is_probe;
        end else begin
          stat[S_WP]  = desc[D_WP];
          wdata[D_USED] = 1'b1;
          wb          = !desc[D_USED] && !is_probe;
          fault       = desc[D_WP] && is_write && !is_probe;
          finish      = fault;
          next_addr   = (lvl == LV_ROOT) ? ptr_addr : page_addr;
          next_lvl    = (lvl == LV_ROOT) ? LV_PTR : LV_PAGE;
        end
      end
      default: begin
        if (desc[1:0] == T_IND) begin
          next_addr = ind_addr;
          next_lvl  = LV_PAGE;
        end else if (desc[1:0] == T_INV) begin
          stat[S_INV] = 1'b1;
          finish      = 1'b1;
          fault       = !is_probe;
        end else begin
          finish      = 1'b1;
          stat[S_WP]  = desc[D_WP];
          stat[S_SUP] = sup_hit;
          fault       = viol && !is_probe;
          if (!fault) begin
            stat[S_RES] = 1'b1;
            stat[S_MOD] = is_probe ? desc[D_MOD] : upd[D_MOD];
            paddr = big_page ? {desc[WORD_W-1:PG8_LO], walk_va[PG8_LO-1:0]}
                             : {desc[WORD_W-1:PG4_LO], walk_va[PG4_LO-1:0]};
            wdata = upd;
            wb    = !is_probe && (upd != desc);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/walk3_xlate.sv
module walk3_xlate
  import walk3_pkg::*;
#(
  parameter int unsigned STAT_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_page,
  input  logic [31:0]       root_sup,
  input  logic [31:0]       root_usr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [2:0]        req_fc,
  input  logic              req_write,
  input  logic              req_probe,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_fault,
  output logic [STAT_W-1:0] rsp_status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [31:0]       mem_rdata
);
  localparam int SUP_BIT = 2;

  state_e            st;
  level_e            lvl;
  logic [WORD_W-1:0] va_q, cur_addr, wb_addr, wdata_q, paddr_q;
  logic              user_q, wr_q, probe_q, fault_q, pend_finish;
  logic [STAT_W-1:0] stat_q;

  logic [WORD_W-1:0] root_addr, ptr_addr, page_addr, ind_addr;
  logic              v_finish, v_fault, v_wb;
  logic [WORD_W-1:0] v_wdata, v_next_addr, v_paddr;
  level_e            v_next_lvl;
  logic [STAT_W-1:0] v_stat;
  logic [STAT_W-1:0] berr_bit;

  always_comb begin
    berr_bit = '0;
    berr_bit[S_BERR] = 1'b1;
  end

  walk3_index u_index (
    .req_va    (req_vaddr),
    .req_sup   (req_fc[SUP_BIT]),
    .root_sup  (root_sup),
    .root_usr  (root_usr),
    .walk_va   (va_q),
    .prev      (mem_rdata),
    .big_page  (cfg_big_page),
    .root_addr (root_addr),
    .ptr_addr  (ptr_addr),
    .page_addr (page_addr),
    .ind_addr  (ind_addr)
  );

  walk3_judge #(.STAT_W(STAT_W)) u_judge (
    .lvl       (lvl),
    .desc      (mem_rdata),
    .walk_va   (va_q),
    .big_page  (cfg_big_page),
    .is_write  (wr_q),
    .is_user   (user_q),
    .is_probe  (probe_q),
    .ptr_addr  (ptr_addr),
    .page_addr (page_addr),
    .ind_addr  (ind_addr),
    .finish    (v_finish),
    .fault     (v_fault),
    .wb        (v_wb),
    .wdata     (v_wdata),
    .next_addr (v_next_addr),
    .next_lvl  (v_next_lvl),
    .stat      (v_stat),
    .paddr     (v_paddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      lvl         <= LV_ROOT;
      va_q        <= '0;
      cur_addr    <= '0;
      wb_addr     <= '0;
      wdata_q     <= '0;
      paddr_q     <= '0;
      user_q      <= 1'b0;
      wr_q        <= 1'b0;
      probe_q     <= 1'b0;
      fault_q     <= 1'b0;
      pend_finish <= 1'b0;
      stat_q      <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q     <= req_vaddr;
            user_q   <= !req_fc[SUP_BIT];
            wr_q     <= req_write;
            probe_q  <= req_probe;
            cur_addr <= root_addr;
            lvl      <= LV_ROOT;
            stat_q   <= '0;
            fault_q  <= 1'b0;
            paddr_q  <= '0;
            st       <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            if (mem_err) begin
              stat_q  <= stat_q | berr_bit;
              fault_q <= !probe_q;
              paddr_q <= '0;
              st      <= ST_RESP;
            end else begin
              stat_q      <= stat_q | v_stat;
              wb_addr     <= cur_addr;
              wdata_q     <= v_wdata;
              pend_finish <= v_finish;
              if (v_finish) begin
                fault_q <= v_fault;
                paddr_q <= v_paddr;
              end else begin
                cur_addr <= v_next_addr;
                lvl      <= v_next_lvl;
              end
              if (v_wb)          st <= ST_WRITE;
              else if (v_finish) st <= ST_RESP;
              else               st <= ST_READ;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (mem_err) begin
              stat_q  <= stat_q | berr_bit;
              fault_q <= !probe_q;
              paddr_q <= '0;
              st      <= ST_RESP;
            end else begin
              st <= pend_finish ? ST_RESP : ST_READ;
            end
          end
        end
        default: begin
          if (rsp_ready) st <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign rsp_valid  = (st == ST_RESP);
  assign rsp_paddr  = paddr_q;
  assign rsp_fault  = fault_q;
  assign rsp_status = stat_q;
  assign mem_req    = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we     = (st == ST_WRITE);
  assign mem_addr   = (st == ST_WRITE) ? wb_addr : cur_addr;
  assign mem_wdata  = wdata_q;

  initial begin
    if (STAT_W < S_USED_W) $display("walk3_xlate: STAT_W too small");
  end
endmodule

// File: rtl/walk3_check.sv
module walk3_check #(
  parameter int unsigned STAT_W = 8
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_probe,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_paddr,
  input logic              rsp_fault,
  input logic [STAT_W-1:0] rsp_status,
  input logic              mem_req,
  input logic              mem_we,
  input logic [31:0]       mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack
);
  logic probe_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) probe_busy <= 1'b0;
    else if (req_valid && req_ready) probe_busy <= req_probe;
    else if (rsp_valid && rsp_ready) probe_busy <= 1'b0;
  end

  // R1 / R2: idle excludes any walk activity
  a_r2_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_fault) && $stable(rsp_status)));

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
      && $stable(mem_addr) && $stable(mem_wdata)));

  a_r6_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[3]);

  a_r12_probe_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    probe_busy |-> !(mem_req && mem_we));

  a_r12_probe_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_busy && rsp_valid) |-> !rsp_fault);

  a_r13_fault_zero_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'd0));
endmodule

bind walk3_xlate walk3_check #(.STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_probe  (req_probe),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault),
  .rsp_status (rsp_status),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack)
);

// File: tb/walk3_xlate_test.sv
module walk3_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [31:0] ERR_ADDR = 32'h0000_3010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_page = 1'b0;
  logic [31:0] root_sup = 32'h0000_2000;
  logic [31:0] root_usr = 32'h0000_1000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [2:0]  req_fc = '0;
  logic        req_write = 1'b0;
  logic        req_probe = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [7:0]  rsp_status;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  walk3_xlate uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int d_rd, d_wr;
  logic [31:0] mem [logic [31:0]];

  typedef struct packed {
    logic [31:0] pa;
    logic        f;
    logic [7:0]  st;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] va4(input int ri, input int pi, input int pg, input int off);
    return {ri[6:0], pi[6:0], pg[5:0], off[11:0]};
  endfunction

  function automatic logic [31:0] va8(input int ri, input int pi, input int pg, input int off);
    return {ri[6:0], pi[6:0], pg[4:0], off[12:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory responder: one idle cycle between acknowledges
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req) begin
        mem_ack = 1'b1;
        if (mem_addr == ERR_ADDR) begin
          mem_err = 1'b1;
        end else begin
          mem_err = 1'b0;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = rd(mem_addr);
            rd_cnt++;
          end
        end
      end
    end
  end

  // monitor: back-pressure pattern plus scoreboard compare
  initial begin
    int tick = 0;
    forever begin
      @(negedge clk);
      rsp_ready = (tick % 3) != 1;
      tick++;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2: unexpected response actual %h expected none", rsp_paddr);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " paddr"}, rsp_paddr, e.pa);
          check({t, " fault"}, {31'd0, rsp_fault}, {31'd0, e.f});
          check({t, " status"}, {24'd0, rsp_status}, {24'd0, e.st});
        end
      end
    end
  end

  task automatic walk(input string tag, input logic [31:0] va, input logic [2:0] fc,
                      input logic wr, input logic pr, input logic [31:0] epa,
                      input logic ef, input logic [7:0] est);
    int r0, w0;
    exp_t e;
    e.pa = epa; e.f = ef; e.st = est;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_fc = fc; req_write = wr; req_probe = pr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    d_rd = rd_cnt - r0;
    d_wr = wr_cnt - w0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mem[32'h1004] = 32'h0000_3002;
    mem[32'h100C] = 32'h0000_300E;
    mem[32'h1010] = 32'h0000_3002;
    mem[32'h1014] = 32'h0000_300A;
    mem[32'h1018] = 32'h0000_300A;
    mem[32'h2004] = 32'h0000_300A;
    mem[32'h3004] = 32'h0000_4002;
    mem[32'h3008] = 32'h0000_6000;
    mem[32'h300C] = 32'h0000_70E2;
    mem[32'h4014] = 32'h0008_0001;
    mem[32'h4018] = 32'h0009_0005;
    mem[32'h401C] = 32'h000A_0081;
    mem[32'h4020] = 32'h0000_5002;
    mem[32'h4024] = 32'h000C_0000;
    mem[32'h5000] = 32'h0000_5102;
    mem[32'h5100] = 32'h000B_0009;
    mem[32'h7008] = 32'h00E0_0009;
    mem[32'h708C] = 32'h00D0_0009;

    repeat (3) @(negedge clk);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // first user read: used bits written at every level
    walk("R4 R8 user read", va4(1,1,5,'h123), 3'd1, 1'b0, 1'b0, 32'h0008_0123, 1'b0, 8'h01);
    check("R3 read count", d_rd, 3);
    check("R3 write count", d_wr, 3);
    check("R6 root used", rd(32'h1004), 32'h0000_300A);
    check("R6 pointer used", rd(32'h3004), 32'h0000_400A);
    check("R11 page used", rd(32'h4014), 32'h0008_0009);

    walk("R11 repeat read", va4(1,1,5,'h123), 3'd1, 1'b0, 1'b0, 32'h0008_0123, 1'b0, 8'h01);
    check("R11 no write when unchanged", d_wr, 0);

    walk("R11 write sets modified", va4(1,1,5,'hABC), 3'd1, 1'b1, 1'b0, 32'h0008_0ABC, 1'b0, 8'h21);
    check("R11 modified write count", d_wr, 1);
    check("R11 page modified", rd(32'h4014), 32'h0008_0019);

    // page write protection
    walk("R7 page wp write", va4(1,1,6,'h010), 3'd1, 1'b1, 1'b0, 32'd0, 1'b1, 8'h04);
    check("R7 no write on fault", d_wr, 0);
    check("R7 page untouched", rd(32'h4018), 32'h0009_0005);
    walk("R7 page wp read", va4(1,1,6,'h010), 3'd1, 1'b0, 1'b0, 32'h0009_0010, 1'b0, 8'h05);
    check("R11 wp page used", rd(32'h4018), 32'h0009_000D);

    // supervisor-only page and supervisor root
    walk("R10 user on sup page", va4(1,1,7,'h044), 3'd1, 1'b0, 1'b0, 32'd0, 1'b1, 8'h08);
    walk("R4 sup root", va4(1,1,7,'h044), 3'd5, 1'b0, 1'b0, 32'h000A_0044, 1'b0, 8'h01);
    check("R4 sup page used", rd(32'h401C), 32'h000A_0089);

    // indirect chain of two
    walk("R9 indirect", va4(1,1,8,'h300), 3'd1, 1'b0, 1'b0, 32'h000B_0300, 1'b0, 8'h01);
    check("R9 read count", d_rd, 5);
    check("R9 write count", d_wr, 0);

    walk("R10 page type 0", va4(1,1,9,0), 3'd1, 1'b0, 1'b0, 32'd0, 1'b1, 8'h02);
    walk("R5 invalid root", va4(2,0,0,0), 3'd1, 1'b0, 1'b0, 32'd0, 1'b1, 8'h02);
    check("R5 root-only read", d_rd, 1);
    walk("R5 invalid pointer", va4(5,2,0,0), 3'd1, 1'b0, 1'b0, 32'd0, 1'b1, 8'h02);
    check("R5 two reads", d_rd, 2);

    // write protection at root level
    walk("R7 root wp write", va4(3,1,5,'h001), 3'd1, 1'b1, 1'b0, 32'd0, 1'b1, 8'h04);
    check("R7 stops at root", d_rd, 1);
    walk("R7 root wp read", va4(3,1,5,'h002), 3'd1, 1'b0, 1'b0, 32'h0008_0002, 1'b0, 8'h25);

    // probe walks
    walk("R12 probe wp write", va4(4,1,6,'h020), 3'd1, 1'b1, 1'b1, 32'h0009_0020, 1'b0, 8'h05);
    check("R12 probe no writes", d_wr, 0);
    check("R12 root used untouched", rd(32'h1010), 32'h0000_3002);
    walk("R12 probe invalid", va4(4,1,9,0), 3'd1, 1'b0, 1'b1, 32'd0, 1'b0, 8'h02);
    walk("R12 probe sup page", va4(4,1,7,'h004), 3'd1, 1'b0, 1'b1, 32'h000A_0004, 1'b0, 8'h09);
    check("R12 probe sup no writes", d_wr, 0);

    // 8 KB pages: pointer bit 7 stays in the base
    cfg_big_page = 1'b1;
    walk("R8 big page", va8(1,3,3,'h1ABC), 3'd1, 1'b0, 1'b0, 32'h00D0_1ABC, 1'b0, 8'h01);
    check("R6 pointer used big", rd(32'h300C), 32'h0000_70EA);
    cfg_big_page = 1'b0;
    walk("R8 small page same pointer", va4(1,3,2,'h0AB), 3'd1, 1'b0, 1'b0, 32'h00E0_00AB, 1'b0, 8'h01);

    // bus error on pointer read
    walk("R13 bus error", va4(6,4,0,0), 3'd1, 1'b0, 1'b0, 32'd0, 1'b1, 8'h10);
    walk("R13 bus error probe", va4(6,4,0,0), 3'd1, 1'b0, 1'b1, 32'd0, 1'b0, 8'h10);

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule